// File: doc/BRIEF.md
# Split-Memory 5x7 Character Dot Generator

This block turns a 6-bit character code and a dot-line index into the five dots of one row of a 5x7 character cell. The cell is not held in one wide memory. It is spread over three narrow lookup memories, and all three read the same 8-bit address. That address is the character code joined with the two low bits of the line index.

The third bit of the line index chooses the memory that drives the four left dots. One memory covers the upper four lines and the other covers the lower three. The same bit also chooses which half of a 2-bit word in the third memory gives the rightmost dot. The glyph contents are a fixed pattern that the package function `glyph_dots` computes.

The result is registered, so a display pipeline can present a new code and line on every clock and read the row one clock later.

Top module: `chargen_split_rom`

## Requirements
- R1: While `rst_n` is low, `dots_o` is 5'b00000.
- R2: For line indices 0 to 3, only the upper-segment memory is enabled, through its active-low enable. Bits 4 to 1 of the row are that memory's word at address {code, line[1:0]}.
- R3: For line indices 4 to 6, only the lower-segment memory is enabled, through its active-low enable. Bits 4 to 1 of the row are that memory's word at address {code, line[1:0]}.
- R4: The fifth-dot memory is always enabled. Bit 0 of the row is bit 0 of its 2-bit word when line[2] is 0, and bit 1 of the word when line[2] is 1.
- R5: For every code 0 to 63 and every line 0 to 6, `dots_o` equals `glyph_dots(code, line)`. Bit 4 is the leftmost dot, bit 0 is the rightmost dot, and a 1 means the dot is lit.
- R6: `dots_o` shows the row for the code and line sampled at the previous rising clock edge.
- R7: A line index of 7 gives 5'b00000 for every code.
- R8: While the code and line are held constant, `dots_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_code_i | input | 6 | Character code, 0 to 63 |
| line_idx_i | input | 3 | Dot-line index; 0 to 6 are valid, 7 gives a blank row |
| dots_o | output | 5 | Registered dot row; bit 4 is the leftmost dot |

## Verification
Every row is due exactly one clock after its code and line are applied. The memories read combinationally and only the output register lies between input and output.

The driver applies stimulus on falling edges and queues one expected row for each cycle it drives. The monitor pops that row one nanosecond after the next rising edge, so each comparison falls in the single cycle the row is defined for. The bench sweeps all 64 codes over all eight line values, then holds one input pair for several cycles to check that the output stays put.

// File: rtl/chargen_pkg.sv
package chargen_pkg;

  localparam int CODE_W = 6;
  localparam int LINE_W = 3;
  localparam int DOT_W  = 5;
  localparam int LINES  = 7;

  // Fixed glyph pattern: bit 4 is the leftmost dot. Code 0 is a blank cell.
  function automatic logic [DOT_W-1:0] glyph_dots(input logic [CODE_W-1:0] code,
                                                  input logic [LINE_W-1:0] line);
    logic [7:0] h;
    if (code == '0 || int'(line) >= LINES) return '0;
    h = 8'({2'b00, code} * 8'd53) + 8'({5'd0, line} * 8'd19) + 8'd7;
    return h[7:3] ^ h[4:0];
  endfunction

endpackage

// File: rtl/chargen_line_dec.sv
module chargen_line_dec
  import chargen_pkg::*;
#(
  parameter int LW = LINE_W
) (
  input  logic [LW-1:0] line_i,
  output logic [LW-2:0] ab_o,
  output logic          c_o,
  output logic          en_upper_n_o,
  output logic          en_lower_n_o,
  output logic          blank_o
);

  localparam logic [LW-1:0] ILLEGAL = LW'(LINES);

  always_comb begin
    ab_o         = line_i[LW-2:0];
    c_o          = line_i[LW-1];
    en_upper_n_o = line_i[LW-1];
    en_lower_n_o = ~line_i[LW-1];
    blank_o      = (line_i == ILLEGAL);
  end

  // R2: lines 0..3 enable only the upper memory
  always_comb begin
    if (line_i < LW'(4)) a_r2_upper_only : assert (!en_upper_n_o && en_lower_n_o);
  end

  // R3: lines 4..6 enable only the lower memory
  always_comb begin
    if (line_i >= LW'(4) && line_i < ILLEGAL) a_r3_lower_only : assert (en_upper_n_o && !en_lower_n_o);
  end

endmodule

// File: rtl/chargen_seg_rom.sv
module chargen_seg_rom
  import chargen_pkg::*;
#(
  parameter int BASE_LINE = 0,
  parameter int AW        = CODE_W + LINE_W - 1,
  parameter int SW        = DOT_W - 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_n_i,
  output logic [SW-1:0] seg_o
);

  localparam int DEPTH = 1 << AW;
  localparam int ABW   = LINE_W - 1;

  logic [SW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam int LN = BASE_LINE + (i % (1 << ABW));
    localparam int CD = i >> ABW;
    localparam logic [DOT_W-1:0] ROW =
      (LN < LINES) ? glyph_dots(CODE_W'(CD), LINE_W'(LN)) : '0;
    assign mem[i] = ROW[DOT_W-1:1];
  end

  // a disabled memory drives zeros onto the shared segment bus
  always_comb begin
    seg_o = en_n_i ? '0 : mem[addr_i];
  end

endmodule

// File: rtl/chargen_fifth_rom.sv
module chargen_fifth_rom
  import chargen_pkg::*;
#(
  parameter int AW = CODE_W + LINE_W - 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          c_i,
  output logic          dot_o
);

  localparam int DEPTH = 1 << AW;
  localparam int ABW   = LINE_W - 1;
  localparam int HALF  = 1 << ABW;

  // bit 0 holds the dot of line ab, bit 1 the dot of line ab + HALF
  logic [1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam int CD  = i >> ABW;
    localparam int LN0 = i % HALF;
    localparam int LN1 = LN0 + HALF;
    localparam logic [DOT_W-1:0] ROW0 = glyph_dots(CODE_W'(CD), LINE_W'(LN0));
    localparam logic [DOT_W-1:0] ROW1 =
      (LN1 < LINES) ? glyph_dots(CODE_W'(CD), LINE_W'(LN1)) : '0;
    assign mem[i] = {ROW1[0], ROW0[0]};
  end

  logic [1:0] word;

  always_comb begin
    word  = mem[addr_i];
    dot_o = c_i ? word[1] : word[0];
  end

endmodule

// File: rtl/chargen_split_rom.sv
module chargen_split_rom
  import chargen_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   char_code_i,
  input  logic [LINE_W-1:0]   line_idx_i,
  output logic [DOT_W-1:0]    dots_o
);

  localparam int ABW = LINE_W - 1;
  localparam int AW  = CODE_W + ABW;
  localparam int SW  = DOT_W - 1;

  logic [ABW-1:0] ab;
  logic           c_bit;
  logic           en_upper_n;
  logic           en_lower_n;
  logic           blank;
  logic [AW-1:0]  addr;
  logic [SW-1:0]  seg_upper;
  logic [SW-1:0]  seg_lower;
  logic           fifth;
  logic [DOT_W-1:0] row_d;
  logic [DOT_W-1:0] row_q;

  chargen_line_dec #(.LW(LINE_W)) u_dec (
    .line_i       (line_idx_i),
    .ab_o         (ab),
    .c_o          (c_bit),
    .en_upper_n_o (en_upper_n),
    .en_lower_n_o (en_lower_n),
    .blank_o      (blank)
  );

  assign addr = {char_code_i, ab};

  chargen_seg_rom #(.BASE_LINE(0), .AW(AW), .SW(SW)) u_rom_upper (
    .addr_i (addr),
    .en_n_i (en_upper_n),
    .seg_o  (seg_upper)
  );

  chargen_seg_rom #(.BASE_LINE(1 << ABW), .AW(AW), .SW(SW)) u_rom_lower (
    .addr_i (addr),
    .en_n_i (en_lower_n),
    .seg_o  (seg_lower)
  );

  chargen_fifth_rom #(.AW(AW)) u_rom_fifth (
    .addr_i (addr),
    .c_i    (c_bit),
    .dot_o  (fifth)
  );

  // next-state: wired-OR segment bus plus fifth dot, blanked for line 7
  always_comb begin
    row_d = {seg_upper | seg_lower, fifth};
    if (blank) row_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  assign dots_o = row_q;

  // R1: reset clears the row
  always_comb begin
    if (rst_n == 1'b0) a_r1_reset_blank : assert (row_q == '0);
  end

  // R7: a line index of 7 yields an empty row on the next cycle
  a_r7_line7_blank : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_idx_i) == LINE_W'(LINES)) |-> (dots_o == '0));

  // R8: inputs held steady keep the row steady
  a_r8_hold_stable : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(char_code_i) && $stable(line_idx_i)) |=> $stable(dots_o));

  // R2/R3: at most one segment memory drives the bus
  a_r2_r3_single_driver : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_upper != '0, seg_lower != '0}));

endmodule

// File: tb/chargen_split_rom_test.sv
`timescale 1ns/1ps
module chargen_split_rom_test;
  import chargen_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [CODE_W-1:0] char_code_i;
  logic [LINE_W-1:0] line_idx_i;
  logic [DOT_W-1:0]  dots_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DOT_W-1:0] ref_tab [64][LINES];
  logic [DOT_W-1:0] exp_q [$];
  string            tag_q [$];

  always #2.5 clk = ~clk;

  chargen_split_rom uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_code_i (char_code_i),
    .line_idx_i  (line_idx_i),
    .dots_o      (dots_o)
  );

  task automatic check(input string req, input logic [DOT_W-1:0] act, input logic [DOT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // driver: apply on falling edge, queue the row due after the next rising edge
  task automatic drive(input int code, input int line, input string req);
    @(negedge clk);
    char_code_i = CODE_W'(code);
    line_idx_i  = LINE_W'(line);
    exp_q.push_back((line < LINES) ? ref_tab[code][line] : '0);
    tag_q.push_back(req);
  endtask

  // monitor: one item matures per rising edge, compared 1 ns later
  always @(posedge clk) begin
    #1;
    if (rst_n === 1'b1 && exp_q.size() > 0) begin
      logic [DOT_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, dots_o, e);
      if (t == "R2" || t == "R3") check("R4", dots_o[0], e[0]);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 64; c++)
      for (int l = 0; l < LINES; l++)
        ref_tab[c][l] = glyph_dots(CODE_W'(c), LINE_W'(l));

    rst_n       = 1'b0;
    char_code_i = 6'd17;
    line_idx_i  = 3'd2;
    repeat (3) @(negedge clk);
    check("R1", dots_o, 5'b00000);
    char_code_i = 6'd40;
    @(negedge clk);
    check("R1", dots_o, 5'b00000);
    rst_n = 1'b1;

    // R6: single item, due exactly one clock later
    drive(33, 1, "R6");
    @(negedge clk);
    char_code_i = 6'd0;
    line_idx_i  = 3'd0;

    // R5 sweep: every code on every line, including line 7 (R7)
    for (int c = 0; c < 64; c++)
      for (int l = 0; l < 8; l++)
        drive(c, l, (l < 4) ? "R2" : (l < LINES) ? "R3" : "R7");

    // R5: lines visited in descending order per code
    for (int c = 63; c >= 0; c -= 7)
      for (int l = LINES - 1; l >= 0; l--)
        drive(c, l, "R5");

    // R8: held inputs keep the row
    for (int k = 0; k < 6; k++) drive(45, 5, "R8");
    for (int k = 0; k < 4; k++) drive(12, 7, "R8");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule